// File: doc/BRIEF.md
# Translation Context Register Bank

This block is the software-visible register file of an address-translation unit that serves four independent translation contexts. Each context owns a window of registers: control, two table-base pairs, a bus-routing selector, two memory-attribute words, a fault status word and a captured fault address. Software reaches all of them through one 32-bit register read/write port. Reads are combinational, and writes take effect on the clock edge.

A context's control register carries a TLB invalidation request. Writing it sends a one-cycle request to the TLB. The bit then acts as a busy flag that software polls, and it drops by itself when the TLB answers on its done input. Translation errors arrive on a sideband port tagged with a context index. The block latches them into that context's status word and keeps the address of the first fault. It raises a shared interrupt for any context whose interrupt enable is set. Software acknowledges a fault by writing zero to the status word. That write also wipes the captured address, so the address must be read first.

Top module: `iommu_ctx_regs`

## Requirements
- R1: After synchronous reset every register of every context reads zero, all contexts are disabled, `irq` is low and `tlb_flush_req` is all zeros.
- R2: A register's byte address is context index × 0x40 plus its offset: control 0x00, bus-route selector 0x0C (bits 2:0), table base 0 low/high 0x10/0x14, table base 1 low/high 0x18/0x1C, status 0x20, attribute words 0x28/0x2C, fault address 0x30. A write reaches only the addressed context and register.
- R3: The control word keeps only bit 0 (translate enable), bit 1 (flush), bit 2 (interrupt enable), bit 3 (remap enable), bits 5:4 (remap table select), bit 16 (access-flag software management) and bit 17 (TRE). All other bits read zero, and writing 0 disables the context.
- R4: A control write with bit 1 set to an idle context sets the flush bit and drives that context's `tlb_flush_req` high for exactly the one cycle after the write edge. The bit reads 1 until the TLB reports completion.
- R5: The flush bit clears at the clock edge where that context's `tlb_flush_done` is high. A done pulse while idle has no effect. A control write with bit 1 set while busy produces no second request and leaves the bit set.
- R6: A fault event for an error-free context latches `flt_flags[0..3]` (translation fault, page fault, walk abort, multiple hit) into status bits 0, 1, 2 and 4, the code into bits 10:8, the level into bits 13:12, and `flt_addr` into the fault-address register. A fault event with no flag bits set is ignored.
- R7: While any status flag is latched, a new fault ORs its flags in but leaves the code, level and fault address of the first fault untouched.
- R8: Writing zero to a status word clears its flags, code and level and zeroes the fault address. A nonzero status write changes nothing.
- R9: `irq` is high exactly when some context has its interrupt enable set and at least one status flag latched.
- R10: Reads of unmapped offsets (0x04, 0x08, 0x24, 0x34 to 0x3C) return zero. Writes there, or to the fault-address register, change nothing.
- R11: A fault that arrives in the same cycle as a zero write to that context's status is captured as a fresh first fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address (context in bits 7:6) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| flt_valid | input | 1 | Fault event strobe |
| flt_ctx | input | 2 | Context of the fault event |
| flt_flags | input | 4 | Fault flags: translation, page, walk abort, multiple hit |
| flt_code | input | 3 | Error code |
| flt_level | input | 2 | Error level |
| flt_addr | input | 32 | Faulting address |
| tlb_flush_req | output | 4 | One-cycle invalidation request per context |
| tlb_flush_done | input | 4 | Invalidation completion per context |
| irq | output | 1 | Combined fault interrupt |

## Verification
On every cycle the assertions check that a flush request lasts one cycle and only appears with the busy bit set, and that a done pulse releases a busy context. They also check that a latched fault holds its address and that a zero status write wipes the status and the address. The bench's scenarios show the rest: the address map and control-bit masking, the exact status encoding of a captured fault, the choice between a clear and a fault in the same cycle, and the interrupt combination across contexts. These checks compare port reads against a reference model, under directed sequences and random traffic.

// File: rtl/iocx_pkg.sv
`timescale 1ns/1ps
package iocx_pkg;

    localparam int DATA_W    = 32;
    localparam int WIN_SHIFT = 6;   // 0x40-byte window per context
    localparam int NFLAG     = 4;

    // control bit positions
    localparam int CB_XLAT  = 0;
    localparam int CB_FLUSH = 1;
    localparam int CB_INTEN = 2;
    localparam int CB_REMAP = 3;
    localparam int CB_RSEL  = 4;
    localparam int CB_AFSW  = 16;
    localparam int CB_TRE   = 17;

    // word index inside a context window
    typedef enum logic [3:0] {
        RI_CTRL  = 4'd0,
        RI_ROUTE = 4'd3,
        RI_TB0L  = 4'd4,
        RI_TB0H  = 4'd5,
        RI_TB1L  = 4'd6,
        RI_TB1H  = 4'd7,
        RI_STAT  = 4'd8,
        RI_ATTR0 = 4'd10,
        RI_ATTR1 = 4'd11,
        RI_FADDR = 4'd12
    } reg_idx_e;

    typedef struct packed {
        logic       tre;
        logic       af_sw;
        logic [1:0] remap_sel;
        logic       remap_en;
        logic       int_en;
        logic       flush;
        logic       xlat_en;
    } ctrl_t;

    typedef struct packed {
        logic [1:0]       level;
        logic [2:0]       code;
        logic [NFLAG-1:0] flags;   // [0] xlat, [1] page, [2] abort, [3] multi-hit
    } stat_t;

    typedef struct packed {
        logic              valid;
        logic [NFLAG-1:0]  flags;
        logic [2:0]        code;
        logic [1:0]        level;
        logic [DATA_W-1:0] addr;
    } fault_t;

    function automatic logic [DATA_W-1:0] ctrl_word(ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CB_XLAT]            = c.xlat_en;
        w[CB_FLUSH]           = c.flush;
        w[CB_INTEN]           = c.int_en;
        w[CB_REMAP]           = c.remap_en;
        w[CB_RSEL+1:CB_RSEL]  = c.remap_sel;
        w[CB_AFSW]            = c.af_sw;
        w[CB_TRE]             = c.tre;
        return w;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[2:0]   = s.flags[2:0];
        w[4]     = s.flags[3];
        w[10:8]  = s.code;
        w[13:12] = s.level;
        return w;
    endfunction

endpackage

// File: rtl/iocx_decode.sv
`timescale 1ns/1ps
module iocx_decode
    import iocx_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int CTX_W  = 2,
    parameter int ADDR_W = CTX_W + WIN_SHIFT
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [CTX_W-1:0]  ctx,
    output reg_idx_e          idx,
    output logic              hit,
    output logic [NCTX-1:0]   wr_sel
);
    logic [3:0] word;
    logic       map_hit;
    logic       unused_lsb;

    assign unused_lsb = ^addr[1:0];
    assign ctx  = addr[ADDR_W-1:WIN_SHIFT];
    assign word = addr[WIN_SHIFT-1:2];

    always_comb begin
        map_hit = 1'b1;
        idx     = RI_CTRL;
        case (word)
            4'd0:  idx = RI_CTRL;
            4'd3:  idx = RI_ROUTE;
            4'd4:  idx = RI_TB0L;
            4'd5:  idx = RI_TB0H;
            4'd6:  idx = RI_TB1L;
            4'd7:  idx = RI_TB1H;
            4'd8:  idx = RI_STAT;
            4'd10: idx = RI_ATTR0;
            4'd11: idx = RI_ATTR1;
            4'd12: idx = RI_FADDR;
            default: map_hit = 1'b0;
        endcase
    end

    assign hit = map_hit && (int'(ctx) < NCTX);

    always_comb begin
        for (int c = 0; c < NCTX; c++) begin
            wr_sel[c] = we && hit && (ctx == CTX_W'(c));
        end
    end

endmodule

// File: rtl/iocx_bank.sv
`timescale 1ns/1ps
module iocx_bank
    import iocx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  reg_idx_e          idx,
    input  logic [DATA_W-1:0] wdata,
    input  fault_t            flt,
    input  logic              flush_done,
    output logic [DATA_W-1:0] rd_word,
    output logic              flush_req,
    output logic              irq
);
    ctrl_t             ctrl_q;
    stat_t             st_q;
    logic [2:0]        route_q;
    logic [DATA_W-1:0] tb_q   [0:3];
    logic [DATA_W-1:0] attr_q [0:1];
    logic [DATA_W-1:0] fadr_q;

    logic [3:0] iw;
    logic       wr_ctrl, wr_tb, wr_attr, clr;
    logic       flush_start, flush_nxt, flt_new;

    assign iw      = idx;
    assign wr_ctrl = wr && (idx == RI_CTRL);
    assign wr_tb   = wr && (idx inside {RI_TB0L, RI_TB0H, RI_TB1L, RI_TB1H});
    assign wr_attr = wr && (idx inside {RI_ATTR0, RI_ATTR1});
    assign clr     = wr && (idx == RI_STAT) && (wdata == '0);
    assign flt_new = flt.valid && (|flt.flags);

    // flush busy flag: set by a request when idle, released by done
    assign flush_start = !ctrl_q.flush && wr_ctrl && wdata[CB_FLUSH];
    assign flush_nxt   = ctrl_q.flush ? !flush_done : flush_start;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            st_q      <= '0;
            route_q   <= '0;
            fadr_q    <= '0;
            flush_req <= 1'b0;
            for (int i = 0; i < 4; i++) tb_q[i] <= '0;
            for (int i = 0; i < 2; i++) attr_q[i] <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.xlat_en   <= wdata[CB_XLAT];
                ctrl_q.int_en    <= wdata[CB_INTEN];
                ctrl_q.remap_en  <= wdata[CB_REMAP];
                ctrl_q.remap_sel <= wdata[CB_RSEL+1:CB_RSEL];
                ctrl_q.af_sw     <= wdata[CB_AFSW];
                ctrl_q.tre       <= wdata[CB_TRE];
            end
            ctrl_q.flush <= flush_nxt;
            flush_req    <= flush_start;

            if (wr && idx == RI_ROUTE) route_q <= wdata[2:0];
            if (wr_tb)   tb_q[iw[1:0]] <= wdata;
            if (wr_attr) attr_q[iw[0]] <= wdata;

            // fault capture: a clear followed by a fault yields a fresh capture
            if (flt_new && (clr || st_q.flags == '0)) begin
                st_q.flags <= flt.flags;
                st_q.code  <= flt.code;
                st_q.level <= flt.level;
                fadr_q     <= flt.addr;
            end else if (clr) begin
                st_q   <= '0;
                fadr_q <= '0;
            end else if (flt_new) begin
                st_q.flags <= st_q.flags | flt.flags;
            end
        end
    end

    always_comb begin
        case (idx)
            RI_CTRL:  rd_word = ctrl_word(ctrl_q);
            RI_ROUTE: rd_word = {{(DATA_W-3){1'b0}}, route_q};
            RI_TB0L, RI_TB0H, RI_TB1L, RI_TB1H: rd_word = tb_q[iw[1:0]];
            RI_STAT:  rd_word = stat_word(st_q);
            RI_ATTR0, RI_ATTR1: rd_word = attr_q[iw[0]];
            RI_FADDR: rd_word = fadr_q;
            default:  rd_word = '0;
        endcase
    end

    assign irq = ctrl_q.int_en && (|st_q.flags);

    AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req); // R4
    AST_FLUSH_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> ctrl_q.flush); // R4
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.flush && flush_done) |=> !ctrl_q.flush); // R5
    AST_FIRST_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
        ((|st_q.flags) && !clr) |=> $stable(fadr_q)); // R7
    AST_CLEAR_WIPES: assert property (@(posedge clk) disable iff (rst)
        (clr && !flt.valid) |=> (st_q == '0 && fadr_q == '0)); // R8

endmodule

// File: rtl/iommu_ctx_regs.sv
`timescale 1ns/1ps
module iommu_ctx_regs
    import iocx_pkg::*;
#(
    parameter int NCTX   = 4,
    parameter int CTX_W  = $clog2(NCTX),
    parameter int ADDR_W = CTX_W + WIN_SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              flt_valid,
    input  logic [CTX_W-1:0]  flt_ctx,
    input  logic [3:0]        flt_flags,
    input  logic [2:0]        flt_code,
    input  logic [1:0]        flt_level,
    input  logic [31:0]       flt_addr,
    output logic [NCTX-1:0]   tlb_flush_req,
    input  logic [NCTX-1:0]   tlb_flush_done,
    output logic              irq
);
    logic [CTX_W-1:0]  dec_ctx;
    reg_idx_e          dec_idx;
    logic              dec_hit;
    logic [NCTX-1:0]   wr_sel;
    logic [DATA_W-1:0] rd_words [0:NCTX-1];
    logic [NCTX-1:0]   ctx_irq;

    iocx_decode #(.NCTX(NCTX), .CTX_W(CTX_W), .ADDR_W(ADDR_W)) u_dec (
        .we     (reg_we),
        .addr   (reg_addr),
        .ctx    (dec_ctx),
        .idx    (dec_idx),
        .hit    (dec_hit),
        .wr_sel (wr_sel)
    );

    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        fault_t flt_c;
        always_comb begin
            flt_c.valid = flt_valid && (flt_ctx == CTX_W'(c));
            flt_c.flags = flt_flags;
            flt_c.code  = flt_code;
            flt_c.level = flt_level;
            flt_c.addr  = flt_addr;
        end
        iocx_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr         (wr_sel[c]),
            .idx        (dec_idx),
            .wdata      (reg_wdata),
            .flt        (flt_c),
            .flush_done (tlb_flush_done[c]),
            .rd_word    (rd_words[c]),
            .flush_req  (tlb_flush_req[c]),
            .irq        (ctx_irq[c])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int c = 0; c < NCTX; c++) begin
            if (dec_hit && dec_ctx == CTX_W'(c)) reg_rdata = rd_words[c];
        end
    end

    assign irq = |ctx_irq;

endmodule

// File: tb/tb_iommu_ctx_regs.sv
`timescale 1ns/1ps
module tb_iommu_ctx_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        flt_valid = 1'b0;
    logic [1:0]  flt_ctx = '0;
    logic [3:0]  flt_flags = '0;
    logic [2:0]  flt_code = '0;
    logic [1:0]  flt_level = '0;
    logic [31:0] flt_addr = '0;
    logic [3:0]  tlb_flush_req;
    logic [3:0]  tlb_flush_done = '0;
    logic        irq;

    always #10 clk = ~clk;   // 50 MHz

    iommu_ctx_regs dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid),
        .flt_ctx(flt_ctx), .flt_flags(flt_flags), .flt_code(flt_code),
        .flt_level(flt_level), .flt_addr(flt_addr), .tlb_flush_req(tlb_flush_req),
        .tlb_flush_done(tlb_flush_done), .irq(irq)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model
    logic [31:0] m_ctrl [0:3];
    logic [31:0] m_route[0:3];
    logic [31:0] m_tb   [0:3][0:3];
    logic [31:0] m_attr [0:3][0:1];
    logic [31:0] m_st   [0:3];
    logic [31:0] m_fa   [0:3];
    logic [3:0]  m_pulse;

    localparam logic [31:0] CTRL_KEEP = 32'h0003_003D;
    localparam logic [31:0] FLAG_BITS = 32'h0000_0017;

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] st_enc(logic [3:0] f, logic [2:0] cd, logic [1:0] lv);
        return {18'd0, lv, 1'b0, cd, 3'd0, f[3], 1'b0, f[2:0]};
    endfunction

    function automatic logic [31:0] exp_read(logic [7:0] a);
        int c = int'(a[7:6]);
        case (a[5:2])
            4'd0:  return m_ctrl[c];
            4'd3:  return m_route[c];
            4'd4, 4'd5, 4'd6, 4'd7: return m_tb[c][int'(a[3:2])];
            4'd8:  return m_st[c];
            4'd10, 4'd11: return m_attr[c][int'(a[2])];
            4'd12: return m_fa[c];
            default: return 32'd0;
        endcase
    endfunction

    function automatic logic exp_irq();
        logic r = 1'b0;
        for (int c = 0; c < 4; c++)
            if (m_ctrl[c][2] && (m_st[c] & FLAG_BITS) != 0) r = 1'b1;
        return r;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        case (a[5:2])
            4'd0: return "R3";
            4'd8: return "R6";
            4'd12: return "R6";
            4'd1, 4'd2, 4'd9, 4'd13, 4'd14, 4'd15: return "R10";
            default: return "R2";
        endcase
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_ctrl[c] = 0; m_route[c] = 0; m_st[c] = 0; m_fa[c] = 0;
            for (int j = 0; j < 4; j++) m_tb[c][j] = 0;
            for (int j = 0; j < 2; j++) m_attr[c][j] = 0;
        end
        m_pulse = 0;
    endtask

    // one clock: called at negedge, returns at next negedge, then checks R4/R9
    task automatic step(bit we, logic [7:0] a, logic [31:0] d,
                        bit fv, logic [1:0] fc, logic [3:0] ff, logic [2:0] fcd,
                        logic [1:0] fl, logic [31:0] fa, logic [3:0] dn);
        reg_we = we; reg_addr = a; reg_wdata = d;
        flt_valid = fv; flt_ctx = fc; flt_flags = ff; flt_code = fcd;
        flt_level = fl; flt_addr = fa; tlb_flush_done = dn;
        @(posedge clk);
        for (int c = 0; c < 4; c++) begin
            bit hit_c = we && (int'(a[7:6]) == c);
            bit wctl  = hit_c && a[5:2] == 4'd0;
            bit busy  = m_ctrl[c][1];
            bit nb    = busy ? !dn[c] : (wctl && d[1]);
            bit clr   = hit_c && a[5:2] == 4'd8 && d == 0;
            bit fnew  = fv && int'(fc) == c && ff != 0;
            m_pulse[c] = !busy && wctl && d[1];
            m_ctrl[c] = ((wctl ? d : m_ctrl[c]) & CTRL_KEEP) | {30'd0, nb, 1'b0};
            if (hit_c && a[5:2] == 4'd3) m_route[c] = {29'd0, d[2:0]};
            if (hit_c && a[5:2] >= 4'd4 && a[5:2] <= 4'd7) m_tb[c][int'(a[3:2])] = d;
            if (hit_c && (a[5:2] == 4'd10 || a[5:2] == 4'd11)) m_attr[c][int'(a[2])] = d;
            if (fnew && (clr || (m_st[c] & FLAG_BITS) == 0)) begin
                m_st[c] = st_enc(ff, fcd, fl); m_fa[c] = fa;
            end else if (clr) begin
                m_st[c] = 0; m_fa[c] = 0;
            end else if (fnew) begin
                m_st[c] = m_st[c] | st_enc(ff, 3'd0, 2'd0);
            end
        end
        @(negedge clk);
        reg_we = 0; flt_valid = 0; tlb_flush_done = 0;
        chk("R4 flush request pulse", {28'd0, tlb_flush_req}, {28'd0, m_pulse});
        chk("R9 interrupt", {31'd0, irq}, {31'd0, exp_irq()});
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        step(1, a, d, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic idle(logic [3:0] dn);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, dn);
    endtask

    task automatic rd(logic [7:0] a, string req);
        reg_we = 0; reg_addr = a;
        #2;
        chk(req, reg_rdata, exp_read(a));
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned s;
        s = $urandom(32'd4242);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: everything zero after reset
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 16; w++) rd(8'(c * 64 + w * 4), "R1 reset value");
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        chk("R1 flush req after reset", {28'd0, tlb_flush_req}, 32'd0);

        // R2: address map and context isolation
        wr(8'h90, 32'hA5A5_0001);   // ctx2 table base 0 low
        wr(8'h4C, 32'hFFFF_FFFF);   // ctx1 route selector
        wr(8'hEC, 32'h1234_5678);   // ctx3 attribute 1
        wr(8'h1C, 32'hCAFE_F00D);   // ctx0 table base 1 high
        for (int c = 0; c < 4; c++)
            for (int w = 0; w < 16; w++) rd(8'(c * 64 + w * 4), "R2 address map");
        chk("R2 route width", exp_read(8'h4C), 32'h7);

        // R3: control masking, disable by writing 0
        wr(8'h00, 32'hFFFF_FFFD);
        rd(8'h00, "R3 control mask");
        chk("R3 control literal", m_ctrl[0], 32'h0003_003D);
        wr(8'h00, 32'h0);
        rd(8'h00, "R3 control disable");

        // R4/R5: flush handshake on ctx1
        wr(8'h40, 32'h2);
        rd(8'h40, "R4 flush busy");
        idle(4'b0000);
        idle(4'b1101);            // done for other contexts only
        rd(8'h40, "R4 flush still busy");
        wr(8'h40, 32'h3);          // rewrite while busy: no pulse
        rd(8'h40, "R5 rewrite while busy");
        idle(4'b0010);
        rd(8'h40, "R5 done clears flush");
        chk("R5 flush literal", exp_read(8'h40), 32'h1);
        idle(4'b0010);             // done while idle
        rd(8'h40, "R5 done while idle");

        // R6: first fault capture on ctx2
        step(0, 0, 0, 1, 2'd2, 4'b0101, 3'd4, 2'd2, 32'h1234_5000, 0);
        rd(8'hA0, "R6 status capture");
        chk("R6 status literal", m_st[2], 32'h0000_2405);
        rd(8'hB0, "R6 fault address");
        step(0, 0, 0, 1, 2'd3, 4'b0000, 3'd1, 2'd1, 32'hDEAD_0000, 0);
        rd(8'hE0, "R6 empty fault ignored");

        // R7: second fault keeps first address
        step(0, 0, 0, 1, 2'd2, 4'b1000, 3'd1, 2'd1, 32'h9999_0000, 0);
        rd(8'hA0, "R7 flags merged");
        chk("R7 status literal", m_st[2], 32'h0000_2415);
        rd(8'hB0, "R7 address kept");

        // R9: interrupt enable
        wr(8'h80, 32'h4);
        chk("R9 irq raised", {31'd0, irq}, 32'd1);

        // R8: nonzero write ignored, zero clears
        wr(8'hA0, 32'h17);
        rd(8'hA0, "R8 nonzero write ignored");
        rd(8'hB0, "R8 address after nonzero write");
        wr(8'hA0, 32'h0);
        rd(8'hA0, "R8 status cleared");
        rd(8'hB0, "R8 address cleared");
        chk("R8 irq dropped", {31'd0, irq}, 32'd0);

        // R11: clear and fault in the same cycle
        step(0, 0, 0, 1, 2'd2, 4'b0010, 3'd5, 2'd3, 32'h0000_7000, 0);
        step(1, 8'hA0, 0, 1, 2'd2, 4'b0001, 3'd1, 2'd0, 32'h0000_8000, 0);
        rd(8'hA0, "R11 fresh capture status");
        rd(8'hB0, "R11 fresh capture address");
        chk("R11 address literal", m_fa[2], 32'h0000_8000);

        // R10: unmapped offsets and read-only fault address
        wr(8'h84, 32'hFFFF_FFFF);
        wr(8'hB0, 32'h0000_FFFF);
        wr(8'hBC, 32'h1);
        foreach (m_ctrl[c]) begin
            rd(8'(c * 64 + 4), "R10 unmapped 0x04");
            rd(8'(c * 64 + 8), "R10 unmapped 0x08");
            rd(8'(c * 64 + 36), "R10 unmapped 0x24");
            rd(8'(c * 64 + 60), "R10 unmapped 0x3C");
        end
        rd(8'hB0, "R10 fault address read-only");

        // random traffic
        for (int i = 0; i < 1500; i++) begin
            logic [7:0]  a = 8'($urandom) & 8'hFC;
            logic [31:0] d = $urandom;
            bit          we = ($urandom % 3) != 0;
            bit          fv = ($urandom % 4) == 0;
            logic [3:0]  dn = 4'($urandom) & 4'($urandom);
            if (a[5:2] == 4'd8 && ($urandom % 2) == 0) d = 0;
            if (a[5:2] == 4'd0) d = d & 32'h0003_00FF;
            step(we, a, d, fv, 2'($urandom), 4'($urandom), 3'($urandom),
                 2'($urandom), $urandom, dn);
            begin
                logic [7:0] ra = 8'($urandom) & 8'hFC;
                rd(ra, tag_of(ra));
            end
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule